// File: doc/BRIEF.md
# Coherent 4-QAM Symbol Demodulator

This block turns a stream of digitised 4-QAM passband samples back into 2-bit symbols. A phase accumulator drives an eight-point quadrature carrier whose phase can be shifted by a static control word. Each accepted sample is multiplied by the local cosine and by the local sine. The product is doubled with a one-bit left shift to restore the baseband level. Each branch then feeds a decimating low-pass FIR whose tap count equals the decimation factor. A single multiply-accumulate per branch therefore covers one whole symbol, and the branch emits one filtered value per window. A sign-only demapper turns each filtered I/Q pair into a symbol with a one-cycle strobe.

No carrier or timing loop is present. Carrier phase and symbol alignment are set by static inputs: `carrier_phase` rotates the local carrier, and `window_offset` discards a number of leading samples so that each FIR window starts on a symbol boundary. The expected passband convention is x = I·cos(θ) + Q·sin(θ).

A two-state window controller sequences the FIR. Reset enters `ST_SKIP`. In `ST_SKIP`, every accepted sample advances a skip counter until the counter equals `window_offset`. That sample, which is the first one not skipped, becomes tap 0 of the first window, and the controller takes the transition to `ST_ACCUM`. `ST_ACCUM` loops on itself and wraps the tap index after the last tap. Only reset takes the controller back to `ST_SKIP`.

Top module: `qam4_demod`

## Requirements
- R1: While reset is high and after it is released with no input, `sym_valid`, `sym`, `sym_i_val` and `sym_q_val` are all zero.
- R2: A 16-bit phase accumulator starts at 0 and adds `carrier_step` on every accepted sample. The carrier index k is bits [15:13] of (accumulator + `carrier_phase`). With A = 1000 and D = floor(A·181/256) = 707, cos(k) for k = 0..7 is A, D, 0, −D, −A, −D, 0, D, and sin(k) = cos((k+6) mod 8).
- R3: Each branch product is the accepted sample times its carrier value, shifted left by one bit (doubled).
- R4: Tap t (0..15) of a window is weighted by 1 + min(t, 15 − t), which gives a symmetric triangle. The window output is the sum over its 16 weighted products, oldest sample at tap 0.
- R5: `sym_valid` is high for exactly one cycle per completed window. It rises after the second rising edge that follows the edge accepting the window's last sample. `sym_i_val` and `sym_q_val` then carry the window sums.
- R6: After reset, the first `window_offset` accepted samples (0..15) are discarded and the next sample starts the first window. Windows of 16 samples follow back to back.
- R7: Samples presented with `in_valid` low do not advance the carrier phase or the window position and do not change any output.
- R8: `sym` encodes the decision as sym[1] = (I < 0) and sym[0] = (I < 0) XOR (Q < 0). This gives I≥0,Q≥0 → 00; I≥0,Q<0 → 01; I<0,Q<0 → 10; I<0,Q≥0 → 11.
- R9: Decisions depend only on the signs of the window sums, so the same transmitted symbols are recovered at very different input amplitudes.
- R10: Each window's sum starts from zero, with no carry-over from the previous window.
- R11: `sym_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 12 | Signed passband sample |
| carrier_step | input | 16 | Phase increment per accepted sample |
| carrier_phase | input | 16 | Static phase correction added to the accumulator |
| window_offset | input | 4 | Number of leading samples discarded before the first window |
| sym_valid | output | 1 | One-cycle strobe per recovered symbol |
| sym | output | 2 | Recovered symbol |
| sym_i_val | output | 38 | Signed in-phase window sum |
| sym_q_val | output | 38 | Signed quadrature window sum |

## Verification
The assertions check the following on every cycle:
- the carrier phase holds across idle samples;
- a mixed sample follows every accepted input;
- the window controller never returns to skipping and never skips past the offset;
- each window result turns into exactly one isolated symbol strobe one cycle later, with the symbol holding otherwise.

Only the bench scenarios can show the rest, by comparing every cycle against a behavioural model:
- that the carrier values, the doubling and the triangle weighting give the right sums;
- that windows are independent;
- that the offset and phase correction align with a transmitted stream;
- that sign decisions recover the sent symbols at both large and small amplitudes.

// File: rtl/qam4_demod_pkg.sv
package qam4_demod_pkg;

    typedef enum logic [0:0] {
        ST_SKIP  = 1'b0,
        ST_ACCUM = 1'b1
    } win_state_t;

    typedef logic [1:0] sym_t;

    // Eight-point cosine level; diagonal points use 181/256 as 1/sqrt(2)
    function automatic int carrier_level(input int idx, input int amp);
        int diag;
        diag = (amp * 181) / 256;
        case (idx & 7)
            0:       return amp;
            1:       return diag;
            2:       return 0;
            3:       return -diag;
            4:       return -amp;
            5:       return -diag;
            6:       return 0;
            default: return diag;
        endcase
    endfunction

    function automatic sym_t sign_decide(input logic i_neg, input logic q_neg);
        return {i_neg, i_neg ^ q_neg};
    endfunction

endpackage

// File: rtl/qam4_carrier_gen.sv
module qam4_carrier_gen
    import qam4_demod_pkg::*;
#(
    parameter int PAW     = 16,
    parameter int CARW    = 12,
    parameter int CAR_AMP = 1000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [PAW-1:0]         step,
    input  logic [PAW-1:0]         phase_ofs,
    output logic signed [CARW-1:0] cos_o,
    output logic signed [CARW-1:0] sin_o
);
    localparam int IDXW = 3;

    logic [PAW-1:0]         phase_acc;
    logic [PAW-1:0]         phase_sum;
    logic [IDXW-1:0]        idx;
    logic signed [CARW-1:0] lut [2**IDXW];

    for (genvar k = 0; k < 2**IDXW; k++) begin : g_lut
        assign lut[k] = CARW'(carrier_level(k, CAR_AMP));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_acc <= '0;
        end else if (in_valid) begin
            phase_acc <= phase_acc + step;
        end
    end

    always_comb begin
        phase_sum = phase_acc + phase_ofs;
        idx       = phase_sum[PAW-1 -: IDXW];
        cos_o     = lut[idx];
        sin_o     = lut[idx - IDXW'(2)];
    end

    // R7: idle input cycles leave the carrier phase untouched
    p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase_acc));

endmodule

// File: rtl/qam4_mixer.sv
module qam4_mixer #(
    parameter int SW   = 12,
    parameter int CARW = 12,
    localparam int MW  = SW + CARW + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [SW-1:0]   sample,
    input  logic signed [CARW-1:0] carrier,
    output logic signed [MW-1:0]   mix
);
    logic signed [SW+CARW-1:0] prod;

    always_comb begin
        prod = sample * carrier;
    end

    // Doubling restores the baseband level halved by the product
    always_ff @(posedge clk) begin
        if (rst) begin
            mix <= '0;
        end else if (in_valid) begin
            mix <= {prod, 1'b0};
        end
    end

endmodule

// File: rtl/qam4_decim_fir.sv
module qam4_decim_fir
    import qam4_demod_pkg::*;
#(
    parameter int DEC        = 16,
    parameter int MW         = 25,
    parameter int CW         = 8,
    parameter int COEF_SHAPE = 1,
    localparam int TW        = $clog2(DEC),
    localparam int OFSW      = $clog2(DEC),
    localparam int PW        = MW + CW + 1,
    localparam int ACC_W     = PW + TW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mix_v,
    input  logic signed [MW-1:0]    mix_i,
    input  logic signed [MW-1:0]    mix_q,
    input  logic [OFSW-1:0]         offset,
    output logic                    out_v,
    output logic signed [ACC_W-1:0] out_i,
    output logic signed [ACC_W-1:0] out_q
);
    localparam logic [TW-1:0] LAST_TAP = TW'(DEC - 1);

    function automatic logic [DEC*CW-1:0] build_coefs();
        logic [DEC*CW-1:0] v;
        int c;
        v = '0;
        for (int k = 0; k < DEC; k++) begin
            if (COEF_SHAPE == 0) begin
                c = 1;
            end else begin
                c = 1 + ((k < DEC - 1 - k) ? k : DEC - 1 - k);
            end
            v[k*CW +: CW] = CW'(c);
        end
        return v;
    endfunction

    localparam logic [DEC*CW-1:0] COEFS = build_coefs();

    win_state_t      state, state_n;
    logic [TW-1:0]   tap, tap_n;
    logic [OFSW-1:0] skip_cnt, skip_n;
    logic            take, first, last;
    logic [CW-1:0]   coef;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_SKIP;
            tap      <= '0;
            skip_cnt <= '0;
        end else begin
            state    <= state_n;
            tap      <= tap_n;
            skip_cnt <= skip_n;
        end
    end

    // Next state and per-sample controls
    always_comb begin
        state_n = state;
        tap_n   = tap;
        skip_n  = skip_cnt;
        take    = 1'b0;
        unique case (state)
            ST_SKIP: begin
                if (mix_v) begin
                    if (skip_cnt == offset) begin
                        take    = 1'b1;
                        tap_n   = TW'(1);
                        state_n = ST_ACCUM;
                    end else begin
                        skip_n = skip_cnt + OFSW'(1);
                    end
                end
            end
            ST_ACCUM: begin
                if (mix_v) begin
                    take  = 1'b1;
                    tap_n = (tap == LAST_TAP) ? '0 : tap + TW'(1);
                end
            end
            default: state_n = ST_SKIP;
        endcase
        first = take && (tap == '0);
        last  = take && (tap == LAST_TAP);
        coef  = COEFS[tap*CW +: CW];
    end

    // Output strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
        end else begin
            out_v <= last;
        end
    end

    logic signed [MW-1:0]    x_br [2];
    logic signed [ACC_W-1:0] res  [2];

    assign x_br[0] = mix_i;
    assign x_br[1] = mix_q;
    assign out_i   = res[0];
    assign out_q   = res[1];

    for (genvar b = 0; b < 2; b++) begin : g_mac
        logic signed [PW-1:0]    prod;
        logic signed [ACC_W-1:0] prod_x;
        logic signed [ACC_W-1:0] acc;

        always_comb begin
            prod   = $signed({1'b0, coef}) * x_br[b];
            prod_x = {{TW{prod[PW-1]}}, prod};
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc    <= '0;
                res[b] <= '0;
            end else begin
                if (take) begin
                    acc <= first ? prod_x : acc + prod_x;
                end
                if (last) begin
                    res[b] <= acc + prod_x;
                end
            end
        end
    end

    // R11: two window results never come back to back
    p_out_gap_r11: assert property (@(posedge clk) disable iff (rst)
        out_v |=> !out_v);

    // R5: a result only follows a cycle that consumed a mixed sample
    p_out_after_sample_r5: assert property (@(posedge clk) disable iff (rst)
        out_v |-> $past(mix_v));

    // R6: skipping never runs past the requested offset
    p_skip_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP) |-> (skip_cnt <= offset));

    // R6: once windows start they stay back to back
    p_accum_stays_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACCUM) |=> (state == ST_ACCUM));

endmodule

// File: rtl/qam4_demapper.sv
module qam4_demapper
    import qam4_demod_pkg::*;
#(
    parameter int ACC_W = 38
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dec_v,
    input  logic signed [ACC_W-1:0] dec_i,
    input  logic signed [ACC_W-1:0] dec_q,
    output logic                    sym_valid,
    output sym_t                    sym,
    output logic signed [ACC_W-1:0] sym_i_val,
    output logic signed [ACC_W-1:0] sym_q_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sym_valid <= 1'b0;
            sym       <= '0;
            sym_i_val <= '0;
            sym_q_val <= '0;
        end else begin
            sym_valid <= dec_v;
            if (dec_v) begin
                sym       <= sign_decide(dec_i[ACC_W-1], dec_q[ACC_W-1]);
                sym_i_val <= dec_i;
                sym_q_val <= dec_q;
            end
        end
    end

    // R5: every window result yields one strobe the next cycle
    p_sym_follow_r5: assert property (@(posedge clk) disable iff (rst)
        dec_v |=> sym_valid);

    // R5: no strobe without a window result
    p_sym_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !dec_v |=> !sym_valid);

    // R8: the decision holds between results
    p_sym_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !dec_v |=> $stable(sym));

endmodule

// File: rtl/qam4_demod.sv
module qam4_demod
    import qam4_demod_pkg::*;
#(
    parameter int SW         = 12,
    parameter int CARW       = 12,
    parameter int PAW        = 16,
    parameter int CAR_AMP    = 1000,
    parameter int DEC        = 16,
    parameter int CW         = 8,
    parameter int COEF_SHAPE = 1,
    localparam int OFSW      = $clog2(DEC),
    localparam int MW        = SW + CARW + 1,
    localparam int ACC_W     = MW + CW + 1 + $clog2(DEC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [SW-1:0]    in_sample,
    input  logic [PAW-1:0]          carrier_step,
    input  logic [PAW-1:0]          carrier_phase,
    input  logic [OFSW-1:0]         window_offset,
    output logic                    sym_valid,
    output logic [1:0]              sym,
    output logic signed [ACC_W-1:0] sym_i_val,
    output logic signed [ACC_W-1:0] sym_q_val
);
    logic signed [CARW-1:0]  car [2];
    logic signed [MW-1:0]    mix [2];
    logic                    mix_v;
    logic                    dec_v;
    logic signed [ACC_W-1:0] dec_i, dec_q;

    qam4_carrier_gen #(
        .PAW     (PAW),
        .CARW    (CARW),
        .CAR_AMP (CAR_AMP)
    ) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .step      (carrier_step),
        .phase_ofs (carrier_phase),
        .cos_o     (car[0]),
        .sin_o     (car[1])
    );

    for (genvar b = 0; b < 2; b++) begin : g_branch
        qam4_mixer #(
            .SW   (SW),
            .CARW (CARW)
        ) u_mix (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .sample   (in_sample),
            .carrier  (car[b]),
            .mix      (mix[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_v <= 1'b0;
        end else begin
            mix_v <= in_valid;
        end
    end

    qam4_decim_fir #(
        .DEC        (DEC),
        .MW         (MW),
        .CW         (CW),
        .COEF_SHAPE (COEF_SHAPE)
    ) u_fir (
        .clk    (clk),
        .rst    (rst),
        .mix_v  (mix_v),
        .mix_i  (mix[0]),
        .mix_q  (mix[1]),
        .offset (window_offset),
        .out_v  (dec_v),
        .out_i  (dec_i),
        .out_q  (dec_q)
    );

    qam4_demapper #(
        .ACC_W (ACC_W)
    ) u_demap (
        .clk       (clk),
        .rst       (rst),
        .dec_v     (dec_v),
        .dec_i     (dec_i),
        .dec_q     (dec_q),
        .sym_valid (sym_valid),
        .sym       (sym),
        .sym_i_val (sym_i_val),
        .sym_q_val (sym_q_val)
    );

    // R7: a mixed sample exists exactly when an input was accepted
    p_mix_follow_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> mix_v);

    p_mix_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !mix_v);

endmodule

// File: tb/sim_qam4_demod.sv
module sim_qam4_demod;
    localparam int SW    = 12;
    localparam int DEC   = 16;
    localparam int ACC_W = 38;
    localparam int AMP   = 1000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [SW-1:0]    in_sample = '0;
    logic [15:0]      carrier_step = '0;
    logic [15:0]      carrier_phase = '0;
    logic [3:0]       window_offset = '0;
    logic             sym_valid;
    logic [1:0]       sym;
    logic [ACC_W-1:0] sym_i_val, sym_q_val;

    always #10 clk = ~clk;

    qam4_demod u0 (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_sample     (in_sample),
        .carrier_step  (carrier_step),
        .carrier_phase (carrier_phase),
        .window_offset (window_offset),
        .sym_valid     (sym_valid),
        .sym           (sym),
        .sym_i_val     (sym_i_val),
        .sym_q_val     (sym_q_val)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    longint m_acc, m_ai, m_aq;
    int     m_skip, m_tap;
    bit     m_run;
    bit     p_v [3];
    longint p_i [3];
    longint p_q [3];
    int     txq [$];
    bit     e2e;
    bit     prev_v;
    string  tag;
    real    tx_ph;
    longint tx_acc;

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint lvl(int k);
        longint d;
        d = (AMP * 181) / 256;
        case (k & 7)
            0: return AMP;
            1: return d;
            2: return 0;
            3: return -d;
            4: return -AMP;
            5: return -d;
            6: return 0;
            default: return d;
        endcase
    endfunction

    function automatic longint weight(int t);
        return 1 + ((t < DEC - 1 - t) ? t : DEC - 1 - t);
    endfunction

    function automatic int map_sym(longint i, longint q);
        return ((i < 0) ? 2 : 0) + (((i < 0) != (q < 0)) ? 1 : 0);
    endfunction

    task automatic model_push(bit v, int x);
        int     idx;
        longint pi, pq, c;
        bit     take;
        p_v[0] = 0; p_i[0] = 0; p_q[0] = 0;
        if (!v) return;
        idx   = int'(((m_acc + longint'(carrier_phase)) & 65535) >> 13);
        pi    = 2 * longint'(x) * lvl(idx);
        pq    = 2 * longint'(x) * lvl((idx + 6) % 8);
        m_acc = (m_acc + longint'(carrier_step)) & 65535;
        take  = 0;
        if (!m_run) begin
            if (m_skip == int'(window_offset)) begin
                take = 1; m_run = 1; m_tap = 0;
            end else begin
                m_skip++;
            end
        end else begin
            take = 1;
        end
        if (take) begin
            c = weight(m_tap);
            if (m_tap == 0) begin
                m_ai = c * pi; m_aq = c * pq;
            end else begin
                m_ai += c * pi; m_aq += c * pq;
            end
            if (m_tap == DEC - 1) begin
                p_v[0] = 1; p_i[0] = m_ai; p_q[0] = m_aq; m_tap = 0;
            end else begin
                m_tap++;
            end
        end
    endtask

    task automatic compare_now();
        check("R5", "sym_valid", longint'(sym_valid), longint'(p_v[2]));
        if (sym_valid) begin
            check("R11", "strobe spacing", longint'(prev_v), 0);
        end
        if (p_v[2] && sym_valid) begin
            check({"R3 R4 R10 ", tag}, "I sum", longint'($signed(sym_i_val)), p_i[2]);
            check({"R3 R4 R10 ", tag}, "Q sum", longint'($signed(sym_q_val)), p_q[2]);
            check("R8", "sign map", longint'(sym), longint'(map_sym(p_i[2], p_q[2])));
            if (e2e && txq.size() > 0) begin
                check({"R8 R9 ", tag}, "sent symbol", longint'(sym), longint'(txq.pop_front()));
            end
        end
        prev_v = sym_valid;
    endtask

    task automatic tick(bit v, int x);
        @(negedge clk);
        compare_now();
        p_v[2] = p_v[1]; p_i[2] = p_i[1]; p_q[2] = p_q[1];
        p_v[1] = p_v[0]; p_i[1] = p_i[0]; p_q[1] = p_q[0];
        model_push(v, x);
        in_valid  = v;
        in_sample = SW'(x);
    endtask

    task automatic do_reset(int ofs, int stp, int pofs, real txp);
        @(negedge clk);
        rst           = 1'b1;
        in_valid      = 1'b0;
        window_offset = 4'(ofs);
        carrier_step  = 16'(stp);
        carrier_phase = 16'(pofs);
        m_acc = 0; m_ai = 0; m_aq = 0; m_skip = 0; m_tap = 0; m_run = 0;
        for (int k = 0; k < 3; k++) begin
            p_v[k] = 0; p_i[k] = 0; p_q[k] = 0;
        end
        txq.delete();
        prev_v = 0;
        tx_ph  = txp;
        tx_acc = 0;
        repeat (2) @(negedge clk);
        check("R1", "reset valid", longint'(sym_valid), 0);
        check("R1", "reset sym", longint'(sym), 0);
        check("R1", "reset I", longint'(sym_i_val), 0);
        check("R1", "reset Q", longint'(sym_q_val), 0);
        rst = 1'b0;
    endtask

    task automatic send_sample(int s, real m);
        real th, iv, qv, val;
        int  x;
        iv  = (s == 0 || s == 1) ? 1.0 : -1.0;
        qv  = (s == 0 || s == 3) ? 1.0 : -1.0;
        th  = 2.0 * 3.14159265358979 * real'(tx_acc) / 65536.0 + tx_ph;
        val = m * (iv * $cos(th) + qv * $sin(th));
        x   = $rtoi(val + ((val >= 0.0) ? 0.5 : -0.5));
        tick(1'b1, x);
        tx_acc = (tx_acc + longint'(carrier_step)) & 65535;
    endtask

    task automatic send_symbol(int s, real m, bit gaps);
        if (e2e) txq.push_back(s);
        for (int j = 0; j < DEC; j++) begin
            if (gaps && (j % 3 == 1)) begin
                tick(1'b0, 1999);
                tick(1'b0, -1999);
            end
            send_sample(s, m);
        end
    endtask

    task automatic flush();
        for (int j = 0; j < 6; j++) tick(1'b0, 0);
    endtask

    int seq1 [10] = '{0, 1, 2, 3, 3, 0, 2, 1, 1, 2};

    initial begin
        // Main pattern: all four symbols, repeats and every transition kind
        tag = "main"; e2e = 1;
        do_reset(0, 8192, 0, 0.0);
        for (int n = 0; n < 10; n++) send_symbol(seq1[n], 1300.0, 0);
        flush();
        check("R5", "all symbols drained", longint'(txq.size()), 0);

        // R9: tiny amplitude, same decisions expected
        tag = "R9";
        do_reset(0, 8192, 0, 0.0);
        for (int n = 9; n >= 0; n--) send_symbol(seq1[n], 40.0, 0);
        flush();
        check("R9", "all symbols drained", longint'(txq.size()), 0);

        // R7: idle cycles with garbage samples inside windows
        tag = "R7";
        do_reset(0, 8192, 0, 0.0);
        for (int n = 0; n < 6; n++) send_symbol(seq1[n], 900.0, 1);
        flush();
        check("R7", "all symbols drained", longint'(txq.size()), 0);

        // R6 and R2: five filler samples, transmitter 90 degrees ahead, corrected
        tag = "R2 R6";
        do_reset(5, 8192, 16384, 3.14159265358979 / 2.0);
        for (int j = 0; j < 5; j++) send_sample(3, 1000.0);
        for (int n = 0; n < 8; n++) send_symbol(seq1[n], 1000.0, 0);
        flush();
        check("R6", "all symbols drained", longint'(txq.size()), 0);

        // R2: slower carrier and an uncorrected phase, value checks only
        tag = "R2"; e2e = 0;
        do_reset(0, 4096, 8192, 0.0);
        for (int n = 0; n < 5; n++) send_symbol(seq1[n], 1200.0, 0);
        flush();

        // R6 boundary: largest offset
        tag = "R6"; e2e = 1;
        do_reset(15, 8192, 0, 0.0);
        for (int j = 0; j < 15; j++) send_sample(1, 1100.0);
        for (int n = 0; n < 4; n++) send_symbol(seq1[n + 2], 1100.0, 0);
        flush();
        check("R6", "all symbols drained", longint'(txq.size()), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule